// File: doc/BRIEF.md
# Tracking-Error Health Monitor

This block produces a single active-low health line for a tracking position converter. It watches three things. The first is the signed loop error, which is the difference between the input angle and the tracked angle, counted in LSBs of the current resolution. The second is the peak amplitude of the sine and cosine signal channels. The third is the peak amplitude of the reference. The amplitudes arrive as unsigned millivolt codes from an external detector. A clock-enable tick is the time base for the persistence delay.

A loop error that is too large is not reported at once. The error has to stay beyond the limit for a parameterized number of ticks before its fault asserts. This means a short transient, such as the settling after a position step, does not trip the line. Signal loss is declared only when both signal channels are weak together. Reference loss is judged on the reference amplitude alone. The health line goes low for any of the three causes, and a separate flag for each cause is also available.

Top module: `bit_mon`

## Requirements
- R1: After reset, and until inputs show a fault, `bitN` is 1 and `faultErr`, `faultSig` and `faultRef` are 0.
- R2: The loop error is out of range when its magnitude is strictly greater than `ERR_LIMIT`. A magnitude equal to `ERR_LIMIT` never raises `faultErr`. This also holds for the most negative code of the error word, whose magnitude is 2^(ERR_W-1).
- R3: Every input is registered once before it is evaluated. While the registered error stays out of range, each clock with `tick`=1 adds one to a persistence count. `faultErr` is 1 exactly when the registered error is out of range and the count has reached `HOLD_TICKS`.
- R4: A single clock whose registered error is within range resets the persistence count to zero. A later excursion therefore needs a full `HOLD_TICKS` ticks again.
- R5: `faultErr` drops in the clock after the first in-range error sample is registered.
- R6: `faultSig` is 1 one clock after an input cycle in which `sinAmp` and `cosAmp` are both strictly below `AMP_MIN`. If either channel is at or above `AMP_MIN`, `faultSig` is 0 one clock later.
- R7: `faultRef` is 1 one clock after an input cycle in which `refAmp` is strictly below `AMP_MIN`, and 0 otherwise. The signal channels have no effect on it.
- R8: `bitN` is 0 exactly when at least one of `faultErr`, `faultSig` or `faultRef` is 1.
- R9: Clocks with `tick`=0 do not advance the persistence count, so an out-of-range error held without ticks never raises `faultErr`.
- R10: The count saturates at `HOLD_TICKS`. `faultErr` therefore stays 1 for as long as the error remains out of range, however long that is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base enable for the persistence count |
| loopErr | input | ERR_W | Signed loop error in LSBs |
| sinAmp | input | AMP_W | Sine channel peak amplitude, mV |
| cosAmp | input | AMP_W | Cosine channel peak amplitude, mV |
| refAmp | input | AMP_W | Reference peak amplitude, mV |
| bitN | output | 1 | Health line, 0 = fault |
| faultErr | output | 1 | Persistent excess-error flag |
| faultSig | output | 1 | Loss-of-signal flag |
| faultRef | output | 1 | Loss-of-reference flag |

## Verification
The hardest case to reach from the ports is an excess error that is interrupted on the last tick before the delay expires. The excursion must be held long enough to approach the limit, broken for exactly one clock, and then resumed. The check must then confirm that a full fresh delay is needed. The bench builds this case directly. It also plays random segments of in-range and out-of-range error with a sparse random tick, so that restarts land at many different count values. Edge codes are driven as directed cases: exactly the limit, the most negative error, and amplitudes on the threshold.

// File: rtl/bit_mon_pkg.sv
package bit_mon_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
  } ctlStrobe_t;

  // registered condition flags from datapath to control
  typedef struct packed {
    logic errOver;
    logic sigLow;
    logic refLow;
    logic cntDone;
  } dpFlags_t;

  localparam int unsigned AMP_CH   = 3;
  localparam int unsigned CH_SIN   = 0;
  localparam int unsigned CH_COS   = 1;
  localparam int unsigned CH_REF   = 2;

endpackage

// File: rtl/bit_mon_dp.sv
module bit_mon_dp
  import bit_mon_pkg::*;
#(
  parameter int unsigned ERR_W      = 18,
  parameter int unsigned AMP_W      = 12,
  parameter int unsigned ERR_LIMIT  = 100,
  parameter int unsigned AMP_MIN    = 500,
  parameter int unsigned HOLD_TICKS = 500
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic signed [ERR_W-1:0] loopErr,
  input  logic [AMP_W-1:0]        sinAmp,
  input  logic [AMP_W-1:0]        cosAmp,
  input  logic [AMP_W-1:0]        refAmp,
  input  ctlStrobe_t              strobe,
  output dpFlags_t                flags
);

  localparam int unsigned MAG_W = ERR_W + 1;
  localparam int unsigned CNT_W = $clog2(HOLD_TICKS + 1);
  localparam logic [MAG_W-1:0] LIMIT_M = MAG_W'(ERR_LIMIT);
  localparam logic [AMP_W-1:0] AMP_TH  = AMP_W'(AMP_MIN);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(HOLD_TICKS);

  // magnitude with one extra bit so the most negative code is exact
  logic [MAG_W-1:0] errExt;
  logic [MAG_W-1:0] errMag;
  always_comb begin
    errExt = {loopErr[ERR_W-1], loopErr};
    errMag = errExt[MAG_W-1] ? (~errExt + MAG_W'(1)) : errExt;
  end

  // per-channel low-amplitude comparators
  logic [AMP_W-1:0] ampIn [AMP_CH];
  logic [AMP_CH-1:0] ampLow;
  assign ampIn[CH_SIN] = sinAmp;
  assign ampIn[CH_COS] = cosAmp;
  assign ampIn[CH_REF] = refAmp;

  for (genvar ch = 0; ch < AMP_CH; ch++) begin : g_amp
    assign ampLow[ch] = ampIn[ch] < AMP_TH;
  end

  logic errOverQ, sigLowQ, refLowQ;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      errOverQ <= 1'b0;
      sigLowQ  <= 1'b0;
      refLowQ  <= 1'b0;
    end else begin
      errOverQ <= errMag > LIMIT_M;
      sigLowQ  <= ampLow[CH_SIN] & ampLow[CH_COS];
      refLowQ  <= ampLow[CH_REF];
    end
  end

  // persistence counter, saturating at CNT_END
  logic [CNT_W-1:0] cnt;
  always_ff @(posedge clk) begin
    if (!rstN)              cnt <= '0;
    else if (strobe.cntClr) cnt <= '0;
    else if (strobe.cntInc) cnt <= cnt + CNT_W'(1);
  end

  always_comb begin
    flags.errOver = errOverQ;
    flags.sigLow  = sigLowQ;
    flags.refLow  = refLowQ;
    flags.cntDone = cnt == CNT_END;
  end

endmodule

// File: rtl/bit_mon_ctl.sv
module bit_mon_ctl
  import bit_mon_pkg::*;
(
  input  logic       tick,
  input  dpFlags_t   flags,
  output ctlStrobe_t strobe,
  output logic       faultErr,
  output logic       faultSig,
  output logic       faultRef,
  output logic       bitN
);

  always_comb begin
    // any in-range sample restarts the persistence window
    strobe.cntClr = ~flags.errOver;
    strobe.cntInc = flags.errOver & tick & ~flags.cntDone;
    faultErr      = flags.errOver & flags.cntDone;
    faultSig      = flags.sigLow;
    faultRef      = flags.refLow;
    bitN          = ~(faultErr | faultSig | faultRef);
  end

endmodule

// File: rtl/bit_mon.sv
module bit_mon
  import bit_mon_pkg::*;
#(
  parameter int unsigned ERR_W      = 18,
  parameter int unsigned AMP_W      = 12,
  parameter int unsigned ERR_LIMIT  = 100,
  parameter int unsigned AMP_MIN    = 500,
  parameter int unsigned HOLD_TICKS = 500
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    tick,
  input  logic signed [ERR_W-1:0] loopErr,
  input  logic [AMP_W-1:0]        sinAmp,
  input  logic [AMP_W-1:0]        cosAmp,
  input  logic [AMP_W-1:0]        refAmp,
  output logic                    bitN,
  output logic                    faultErr,
  output logic                    faultSig,
  output logic                    faultRef
);

  ctlStrobe_t strobe;
  dpFlags_t   flags;

  bit_mon_dp #(
    .ERR_W(ERR_W), .AMP_W(AMP_W), .ERR_LIMIT(ERR_LIMIT),
    .AMP_MIN(AMP_MIN), .HOLD_TICKS(HOLD_TICKS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .loopErr(loopErr),
    .sinAmp(sinAmp), .cosAmp(cosAmp), .refAmp(refAmp),
    .strobe(strobe), .flags(flags)
  );

  bit_mon_ctl u_ctl (
    .tick(tick), .flags(flags), .strobe(strobe),
    .faultErr(faultErr), .faultSig(faultSig), .faultRef(faultRef),
    .bitN(bitN)
  );

endmodule

// File: rtl/bit_mon_chk.sv
module bit_mon_chk #(
  parameter int unsigned ERR_W     = 18,
  parameter int unsigned AMP_W     = 12,
  parameter int unsigned ERR_LIMIT = 100,
  parameter int unsigned AMP_MIN   = 500
) (
  input logic                    clk,
  input logic                    rstN,
  input logic signed [ERR_W-1:0] loopErr,
  input logic [AMP_W-1:0]        sinAmp,
  input logic [AMP_W-1:0]        cosAmp,
  input logic [AMP_W-1:0]        refAmp,
  input logic                    bitN,
  input logic                    faultErr,
  input logic                    faultSig,
  input logic                    faultRef
);

  logic signed [ERR_W:0] errWide;
  logic errOut;
  always_comb begin
    errWide = {loopErr[ERR_W-1], loopErr};
    errOut  = (errWide > $signed((ERR_W+1)'(ERR_LIMIT))) ||
              (errWide < -$signed((ERR_W+1)'(ERR_LIMIT)));
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rstN |=> (bitN && !faultErr && !faultSig && !faultRef));

  // R5
  err_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !errOut |=> !faultErr);

  // R10
  err_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (faultErr && errOut) |=> faultErr);

  // R6
  sig_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinAmp < AMP_W'(AMP_MIN) && cosAmp < AMP_W'(AMP_MIN)) |=> faultSig);

  // R6
  sig_ok_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinAmp >= AMP_W'(AMP_MIN) || cosAmp >= AMP_W'(AMP_MIN)) |=> !faultSig);

  // R7
  ref_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refAmp < AMP_W'(AMP_MIN)) |=> faultRef);

  // R7
  ref_ok_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refAmp >= AMP_W'(AMP_MIN)) |=> !faultRef);

  // R8
  line_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (faultErr || faultSig || faultRef) |-> !bitN);

  // R8
  line_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(faultErr || faultSig || faultRef) |-> bitN);

endmodule

bind bit_mon bit_mon_chk #(
  .ERR_W(ERR_W), .AMP_W(AMP_W), .ERR_LIMIT(ERR_LIMIT), .AMP_MIN(AMP_MIN)
) u_chk (
  .clk(clk), .rstN(rstN), .loopErr(loopErr),
  .sinAmp(sinAmp), .cosAmp(cosAmp), .refAmp(refAmp),
  .bitN(bitN), .faultErr(faultErr), .faultSig(faultSig), .faultRef(faultRef)
);

// File: tb/tb_bit_mon.sv
`timescale 1ns/1ps
module tb_bit_mon;

  localparam int ERR_W = 18;
  localparam int AMP_W = 12;
  localparam int LIM   = 100;
  localparam int AMIN  = 500;
  localparam int HOLD  = 40;

  logic clk = 1'b0;
  logic rstN;
  logic tick;
  logic signed [ERR_W-1:0] loopErr;
  logic [AMP_W-1:0] sinAmp, cosAmp, refAmp;
  logic bitN, faultErr, faultSig, faultRef;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  bit_mon #(
    .ERR_W(ERR_W), .AMP_W(AMP_W), .ERR_LIMIT(LIM),
    .AMP_MIN(AMIN), .HOLD_TICKS(HOLD)
  ) dut (
    .clk(clk), .rstN(rstN), .tick(tick), .loopErr(loopErr),
    .sinAmp(sinAmp), .cosAmp(cosAmp), .refAmp(refAmp),
    .bitN(bitN), .faultErr(faultErr), .faultSig(faultSig), .faultRef(faultRef)
  );

  // reference model built from the requirements
  bit mOver, mSig, mRef;
  int mCnt;

  function automatic bit errOutside(logic signed [ERR_W-1:0] e);
    longint v;
    v = e;
    if (v < 0) v = -v;
    return v > LIM;
  endfunction

  function automatic bit expErr();
    return mOver && (mCnt == HOLD);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mOver <= 0; mSig <= 0; mRef <= 0; mCnt <= 0;
    end else begin
      mOver <= errOutside(loopErr);
      mSig  <= (sinAmp < AMIN) && (cosAmp < AMIN);
      mRef  <= refAmp < AMIN;
      if (!mOver) mCnt <= 0;
      else if (tick && mCnt < HOLD) mCnt <= mCnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // full comparison of all outputs against the model, away from the edge
  task automatic cmpAll();
    bit eE, eL;
    eE = expErr();
    eL = !(eE || mSig || mRef);
    check(faultErr == eE, "R3", faultErr, eE);
    check(faultSig == mSig, "R6", faultSig, mSig);
    check(faultRef == mRef, "R7", faultRef, mRef);
    check(bitN == eL, "R8", bitN, eL);
  endtask

  task automatic step(input bit tk, input logic signed [ERR_W-1:0] e);
    tick = tk;
    loopErr = e;
    @(posedge clk);
    #1.25;
    cmpAll();
  endtask

  task automatic setAmp(input int s, input int c, input int r);
    sinAmp = AMP_W'(s); cosAmp = AMP_W'(c); refAmp = AMP_W'(r);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rstN = 0; tick = 0; loopErr = '0;
    setAmp(2000, 2000, 2000);
    repeat (3) @(posedge clk);
    #1.25;
    // R1 reset state
    check(bitN == 1 && !faultErr && !faultSig && !faultRef, "R1", bitN, 1);
    @(negedge clk);
    rstN = 1;
    repeat (3) step(1, '0);
    check(bitN == 1, "R1", bitN, 1);

    // R2: exactly the limit never faults
    repeat (HOLD + 10) step(1, ERR_W'(-LIM));
    check(faultErr == 0, "R2", faultErr, 0);
    repeat (HOLD + 10) step(1, ERR_W'(LIM));
    check(faultErr == 0, "R2", faultErr, 0);

    // R3: one beyond the limit faults after the delay
    step(1, ERR_W'(LIM + 1));
    repeat (HOLD - 1) step(1, ERR_W'(LIM + 1));
    check(faultErr == 0, "R3", faultErr, 0);
    step(1, ERR_W'(LIM + 1));
    check(faultErr == 1 && bitN == 0, "R3", faultErr, 1);
    // R10: stays asserted while the excursion lasts
    repeat (3 * HOLD) step(1, ERR_W'(-LIM - 1));
    check(faultErr == 1, "R10", faultErr, 1);
    // R5: drops one clock after the in-range sample is registered
    step(1, '0);
    check(faultErr == 0, "R5", faultErr, 0);

    // R4: break on the last tick restarts the window
    repeat (HOLD) step(1, ERR_W'(300));
    step(1, ERR_W'(5));
    check(faultErr == 0, "R4", faultErr, 0);
    repeat (HOLD) step(1, ERR_W'(300));
    check(faultErr == 0, "R4", faultErr, 0);
    step(1, ERR_W'(300));
    check(faultErr == 1, "R4", faultErr, 1);
    step(1, '0); step(1, '0);

    // R9: no ticks, no progress
    repeat (4 * HOLD) step(0, ERR_W'(-500));
    check(faultErr == 0, "R9", faultErr, 0);
    step(1, ERR_W'(-500));

    // R2: most negative error code counts as out of range
    repeat (HOLD + 3) step(1, {1'b1, {(ERR_W-1){1'b0}}});
    check(faultErr == 1, "R2", faultErr, 1);
    step(1, '0); step(1, '0);

    // R6: one weak channel is not a loss, both are
    setAmp(499, 500, 2000); step(1, '0);
    step(1, '0);
    check(faultSig == 0, "R6", faultSig, 0);
    setAmp(499, 499, 2000); step(1, '0);
    check(faultSig == 1 && bitN == 0, "R6", faultSig, 1);
    setAmp(2000, 0, 2000); step(1, '0);
    check(faultSig == 0, "R6", faultSig, 0);

    // R7: reference alone, signals have no effect on it
    setAmp(0, 0, 499); step(1, '0);
    check(faultRef == 1 && faultSig == 1, "R7", faultRef, 1);
    setAmp(0, 0, 500); step(1, '0);
    check(faultRef == 0, "R7", faultRef, 0);
    setAmp(2000, 2000, 2000); step(1, '0);
    check(bitN == 1, "R8", bitN, 1);

    // random segments
    for (int seg = 0; seg < 400; seg++) begin
      int len;
      int kind;
      len  = 1 + int'($urandom_range(90));
      kind = int'($urandom_range(3));
      for (int i = 0; i < len; i++) begin
        logic signed [ERR_W-1:0] e;
        int mag;
        mag = (kind == 0) ? int'($urandom_range(LIM)) : LIM + 1 + int'($urandom_range(2000));
        e = ($urandom_range(1) == 1) ? ERR_W'(-mag) : ERR_W'(mag);
        if ($urandom_range(15) == 0)
          setAmp(int'($urandom_range(1000)), int'($urandom_range(1000)),
                 int'($urandom_range(1000)));
        step($urandom_range(3) != 0, e);
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule